// File: doc/BRIEF.md
# Protection FET Drive and Power-Mode Controller

This block decides the drive levels for the three protection transistors of a multi-cell battery pack: charge, discharge and pre-charge. It also decides whether the supply regulator runs, whether cell-voltage monitoring is active, and which power mode the device is in. A host controller writes a three-bit transistor code and a monitor-selector code through a serial front end, which presents each code here with a one-cycle write strobe. Two override pins let the host switch transistors off without using the serial path. On every output a high level means the transistor is off.

The device has three power modes. In usual mode monitoring runs. In power-save mode the analog selector outputs ground, monitoring stops and the regulator stays on. In power-down mode every transistor is off and the regulator is disabled. A power-down request is refused while a charger is attached. Once in power-down, the device waits for a charger to appear, which switches the regulator back on. The host then sends a resume request, and normal operation restarts from a safe, all-off state. The charger-present pin is asynchronous and passes through a synchronizer with a parameterized number of stages.

Top module: `prot_fet_pwr_ctrl`

## Requirements
- R1: After reset, `chg_off`, `dis_off` and `pre_off` are all 1, `reg_en` is 1, `mon_en` is 0, and `pwr_mode` is 2'b01 (power-save).
- R2: In run operation, `fet_wr` loads `fet_code` at the clock edge. Bit 2 set drives `chg_off` low, bit 1 set drives `dis_off` low, and bit 0 set drives `pre_off` low. A clear bit leaves its output high.
- R3: While `dis_ovr` is 1, `dis_off` is 1 in the same cycle, whatever the stored code.
- R4: While `chg_ovr` is 1, `chg_off` and `pre_off` are both 1 in the same cycle, whatever the stored code.
- R5: `mux_wr` with `mux_code` 3'b001 selects usual mode (`pwr_mode` 2'b00, `mon_en` 1). Codes 3'b000, 3'b010 and 3'b011 select power-save (`pwr_mode` 2'b01, `mon_en` 0). Codes 3'b100 to 3'b111 are ignored.
- R6: `pd_req` in run operation with no charger seen enters power-down at the next edge. Power-down gives all three FET outputs 1, `reg_en` 0, `mon_en` 0 and `pwr_mode` 2'b10.
- R7: `pd_req` has no effect while the synchronized charger input is 1.
- R8: In power-down, `fet_wr`, `mux_wr` and `resume_req` have no effect, and all FET outputs stay 1 whatever the overrides are.
- R9: In power-down, `charger_in` held at 1 sets `reg_en` to 1 within SYNC_STAGES+1 edges. `pwr_mode` stays 2'b10 and all FET outputs stay 1.
- R10: `resume_req` after the charger has been seen in power-down returns the block to run operation. The stored transistor code becomes all-off and the selector becomes ground, so `pwr_mode` reads 2'b01. In run operation `resume_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fet_wr | input | 1 | Strobe: load transistor code |
| fet_code | input | 3 | Transistor code, a set bit switches that FET on |
| mux_wr | input | 1 | Strobe: load monitor-selector code |
| mux_code | input | 3 | Monitor-selector code |
| pd_req | input | 1 | Strobe: power-down request |
| resume_req | input | 1 | Strobe: resume from power-down |
| charger_in | input | 1 | Charger present, asynchronous |
| dis_ovr | input | 1 | Forces the discharge FET off |
| chg_ovr | input | 1 | Forces the charge and pre-charge FETs off |
| chg_off | output | 1 | Charge FET drive, 1 = off |
| dis_off | output | 1 | Discharge FET drive, 1 = off |
| pre_off | output | 1 | Pre-charge FET drive, 1 = off |
| reg_en | output | 1 | Regulator enable |
| mon_en | output | 1 | Cell-voltage monitoring enable |
| pwr_mode | output | 2 | 00 usual, 01 power-save, 10 power-down |

## Verification
The assertions assume that the strobes `fet_wr`, `mux_wr`, `pd_req` and `resume_req` are synchronous to `clk` and last one cycle. They also assume that `charger_in` stays stable long enough to pass the synchronizer. The stimulus changes every input shortly after a rising edge and raises each strobe for exactly one cycle. It holds the charger level for SYNC_STAGES+1 edges before it checks anything that depends on it. The override pins are the only inputs expected to act within a cycle, and the checks sample them in the same cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int FET_W = 3;
    localparam int MUX_W = 3;

    // bit positions within the transistor code
    localparam int PRE_BIT = 0;
    localparam int DIS_BIT = 1;
    localparam int CHG_BIT = 2;

    localparam logic [MUX_W-1:0] MUX_GROUND   = 3'b000;
    localparam logic [MUX_W-1:0] MUX_MONITOR  = 3'b001;
    localparam logic [MUX_W-1:0] MUX_LAST_OK  = 3'b011;

    typedef enum logic [1:0] {
        MODE_USUAL = 2'b00,
        MODE_SAVE  = 2'b01,
        MODE_DOWN  = 2'b10
    } pwr_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_DOWN = 2'b01,
        ST_WAKE = 2'b10
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e       st;
        logic [FET_W-1:0] fet;
        logic [MUX_W-1:0] mux;
    } ctl_t;
endpackage

// File: rtl/fpm_sync.sv
module fpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain_d, chain_q;

    generate
        if (N == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[N-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[N-1];
endmodule

// File: rtl/fpm_fet_map.sv
module fpm_fet_map
    import fpm_pkg::*;
(
    input  logic [FET_W-1:0] code,
    input  logic             dis_ovr,
    input  logic             chg_ovr,
    input  logic             force_off,
    output logic             chg_off,
    output logic             dis_off,
    output logic             pre_off
);
    logic [FET_W-1:0] off_lvl;
    logic [FET_W-1:0] ovr_mask;

    // per-FET override mask: charge override covers charge and pre-charge
    always_comb begin
        ovr_mask          = '0;
        ovr_mask[PRE_BIT] = chg_ovr;
        ovr_mask[CHG_BIT] = chg_ovr;
        ovr_mask[DIS_BIT] = dis_ovr;
    end

    generate
        for (genvar i = 0; i < FET_W; i++) begin : g_lvl
            always_comb off_lvl[i] = force_off | ovr_mask[i] | ~code[i];
        end
    endgenerate

    assign chg_off = off_lvl[CHG_BIT];
    assign dis_off = off_lvl[DIS_BIT];
    assign pre_off = off_lvl[PRE_BIT];
endmodule

// File: rtl/fpm_mode_ctl.sv
module fpm_mode_ctl
    import fpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             charger_s,
    input  logic             pd_req,
    input  logic             resume_req,
    input  logic             fet_wr,
    input  logic [FET_W-1:0] fet_code,
    input  logic             mux_wr,
    input  logic [MUX_W-1:0] mux_code,
    output pwr_state_e       state,
    output logic [FET_W-1:0] fet_q_o,
    output logic [MUX_W-1:0] mux_q_o
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_RUN: begin
                if (pd_req && !charger_s) begin
                    ctl_d.st = ST_DOWN;
                end else begin
                    if (fet_wr) ctl_d.fet = fet_code;
                    if (mux_wr && (mux_code <= MUX_LAST_OK)) ctl_d.mux = mux_code;
                end
            end
            ST_DOWN: begin
                if (charger_s) ctl_d.st = ST_WAKE;
            end
            ST_WAKE: begin
                if (resume_req) begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.fet = '0;
                    ctl_d.mux = MUX_GROUND;
                end
            end
            default: ctl_d.st = ST_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_RUN;
            ctl_q.fet <= '0;
            ctl_q.mux <= MUX_GROUND;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state   = ctl_q.st;
    assign fet_q_o = ctl_q.fet;
    assign mux_q_o = ctl_q.mux;

    // R6
    pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && pd_req && !charger_s) |=> (ctl_q.st == ST_DOWN));

    // R7
    pd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && pd_req && charger_s) |=> (ctl_q.st == ST_RUN));

    // R8
    down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_RUN && !(ctl_q.st == ST_WAKE && resume_req))
        |=> ($stable(ctl_q.fet) && $stable(ctl_q.mux) && ctl_q.st != ST_RUN));

    // R10
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAKE && resume_req)
        |=> (ctl_q.st == ST_RUN && ctl_q.fet == '0 && ctl_q.mux == MUX_GROUND));
endmodule

// File: rtl/prot_fet_pwr_ctrl.sv
module prot_fet_pwr_ctrl
    import fpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fet_wr,
    input  logic [2:0] fet_code,
    input  logic       mux_wr,
    input  logic [2:0] mux_code,
    input  logic       pd_req,
    input  logic       resume_req,
    input  logic       charger_in,
    input  logic       dis_ovr,
    input  logic       chg_ovr,
    output logic       chg_off,
    output logic       dis_off,
    output logic       pre_off,
    output logic       reg_en,
    output logic       mon_en,
    output logic [1:0] pwr_mode
);
    logic             charger_s;
    pwr_state_e       state;
    logic [FET_W-1:0] fet_q;
    logic [MUX_W-1:0] mux_q;
    logic             down_any;

    fpm_sync #(.STAGES(SYNC_STAGES)) u_chg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (charger_in),
        .dout  (charger_s)
    );

    fpm_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .charger_s  (charger_s),
        .pd_req     (pd_req),
        .resume_req (resume_req),
        .fet_wr     (fet_wr),
        .fet_code   (fet_code),
        .mux_wr     (mux_wr),
        .mux_code   (mux_code),
        .state      (state),
        .fet_q_o    (fet_q),
        .mux_q_o    (mux_q)
    );

    assign down_any = (state != ST_RUN);

    fpm_fet_map u_map (
        .code      (fet_q),
        .dis_ovr   (dis_ovr),
        .chg_ovr   (chg_ovr),
        .force_off (down_any),
        .chg_off   (chg_off),
        .dis_off   (dis_off),
        .pre_off   (pre_off)
    );

    always_comb begin
        reg_en = (state != ST_DOWN);
        mon_en = (state == ST_RUN) && (mux_q == MUX_MONITOR);
        if (down_any)    pwr_mode = MODE_DOWN;
        else if (mon_en) pwr_mode = MODE_USUAL;
        else             pwr_mode = MODE_SAVE;
    end

    // R3
    dis_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_ovr |-> dis_off);

    // R4
    chg_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_ovr |-> (chg_off && pre_off));

    // R6
    down_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == MODE_DOWN) |-> (chg_off && dis_off && pre_off && !mon_en));

    // R5
    mon_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |-> (pwr_mode == MODE_USUAL && reg_en));
endmodule

// File: tb/prot_fet_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module prot_fet_pwr_ctrl_bench;
    localparam int SYNC = 2;

    typedef struct {
        logic [2:0] offs;   // {chg_off, dis_off, pre_off}
        logic       reg_en;
        logic       mon_en;
        logic [1:0] mode;
        string      tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic fet_wr = 0, mux_wr = 0, pd_req = 0, resume_req = 0;
    logic charger_in = 0, dis_ovr = 0, chg_ovr = 0;
    logic [2:0] fet_code = 0, mux_code = 0;
    logic chg_off, dis_off, pre_off, reg_en, mon_en;
    logic [1:0] pwr_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    prot_fet_pwr_ctrl #(.SYNC_STAGES(SYNC)) u_prot_fet_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .fet_wr(fet_wr), .fet_code(fet_code),
        .mux_wr(mux_wr), .mux_code(mux_code), .pd_req(pd_req),
        .resume_req(resume_req), .charger_in(charger_in), .dis_ovr(dis_ovr),
        .chg_ovr(chg_ovr), .chg_off(chg_off), .dis_off(dis_off),
        .pre_off(pre_off), .reg_en(reg_en), .mon_en(mon_en), .pwr_mode(pwr_mode)
    );

    // expected FET levels from the requirement text: set code bit => FET on (low)
    function automatic logic [2:0] fet_exp(logic [2:0] code, logic d_o, logic c_o, logic down);
        logic [2:0] r;
        r = ~code;
        if (d_o) r[1] = 1'b1;
        if (c_o) begin r[2] = 1'b1; r[0] = 1'b1; end
        if (down) r = 3'b111;
        return r;
    endfunction

    task automatic expect_now(logic [2:0] offs, logic re, logic me, logic [1:0] md, string tag);
        exp_t e;
        e.offs = offs; e.reg_en = re; e.mon_en = me; e.mode = md; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic strobe_fet(logic [2:0] c);
        fet_code = c; fet_wr = 1; @(posedge clk); #1; fet_wr = 0;
    endtask
    task automatic strobe_mux(logic [2:0] c);
        mux_code = c; mux_wr = 1; @(posedge clk); #1; mux_wr = 0;
    endtask
    task automatic strobe_pd();
        pd_req = 1; @(posedge clk); #1; pd_req = 0;
    endtask
    task automatic strobe_resume();
        resume_req = 1; @(posedge clk); #1; resume_req = 0;
    endtask
    task automatic settle_charger(logic v);
        charger_in = v; repeat (SYNC + 1) @(posedge clk); #1;
    endtask

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if ({chg_off, dis_off, pre_off} !== e.offs || reg_en !== e.reg_en ||
                    mon_en !== e.mon_en || pwr_mode !== e.mode) begin
                    n_fail++;
                    $display("FAIL %s: got fet=%b reg=%b mon=%b mode=%b, expected fet=%b reg=%b mon=%b mode=%b",
                             e.tag, {chg_off, dis_off, pre_off}, reg_en, mon_en, pwr_mode,
                             e.offs, e.reg_en, e.mon_en, e.mode);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        expect_now(3'b111, 1, 0, 2'b01, "R1 reset");

        // R2 every code
        for (int c = 0; c < 8; c++) begin
            strobe_fet(3'(c));
            expect_now(fet_exp(3'(c), 0, 0, 0), 1, 0, 2'b01, "R2 code map");
        end

        // R5 selector
        strobe_mux(3'b001); expect_now(fet_exp(3'b111, 0, 0, 0), 1, 1, 2'b00, "R5 monitor");
        strobe_mux(3'b110); expect_now(fet_exp(3'b111, 0, 0, 0), 1, 1, 2'b00, "R5 code 110 ignored");
        strobe_mux(3'b011); expect_now(fet_exp(3'b111, 0, 0, 0), 1, 0, 2'b01, "R5 ground 011");
        strobe_mux(3'b001);
        strobe_mux(3'b010); expect_now(fet_exp(3'b111, 0, 0, 0), 1, 0, 2'b01, "R5 ground 010");
        strobe_mux(3'b001);

        // R3 / R4 overrides, same cycle
        dis_ovr = 1; #0.5;
        expect_now(fet_exp(3'b111, 1, 0, 0), 1, 1, 2'b00, "R3 discharge override");
        chg_ovr = 1; #0.5;
        expect_now(fet_exp(3'b111, 1, 1, 0), 1, 1, 2'b00, "R4 both overrides");
        dis_ovr = 0; #0.5;
        expect_now(fet_exp(3'b111, 0, 1, 0), 1, 1, 2'b00, "R4 charge override");
        chg_ovr = 0; #0.5;
        expect_now(fet_exp(3'b111, 0, 0, 0), 1, 1, 2'b00, "R3 overrides released");

        // R7 refused with charger
        settle_charger(1);
        strobe_pd();
        expect_now(fet_exp(3'b111, 0, 0, 0), 1, 1, 2'b00, "R7 pd refused");

        // R6 power-down
        settle_charger(0);
        strobe_pd();
        expect_now(3'b111, 0, 0, 2'b10, "R6 power-down");

        // R8 writes and resume ignored while down
        strobe_fet(3'b111);
        strobe_mux(3'b001);
        strobe_resume();
        dis_ovr = 0; chg_ovr = 0;
        expect_now(3'b111, 0, 0, 2'b10, "R8 down ignores inputs");

        // R9 charger wakes regulator
        settle_charger(1);
        expect_now(3'b111, 1, 0, 2'b10, "R9 regulator back");
        strobe_fet(3'b111);
        expect_now(3'b111, 1, 0, 2'b10, "R8 write ignored while waiting");

        // R10 resume to safe state
        strobe_resume();
        expect_now(3'b111, 1, 0, 2'b01, "R10 resume all-off ground");
        strobe_fet(3'b101);
        expect_now(fet_exp(3'b101, 0, 0, 0), 1, 0, 2'b01, "R2 after resume");
        strobe_resume();
        expect_now(fet_exp(3'b101, 0, 0, 0), 1, 0, 2'b01, "R10 resume ignored in run");

        @(posedge clk); @(negedge clk); #1;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule